// File: doc/BRIEF.md
# Instrument Status and Service-Request Registers

This block keeps the status state of a programmable instrument in the IEEE 488.2 style. Each clock cycle it takes fault events, standard events and two queue flags. Fault and standard events are held in sticky event registers. Enable masks decide which held bits reach the summary bits of an 8-bit status byte. A second mask then reduces the status byte to one service-request line. The block also drives a shutdown line from the raw fault inputs. For two operating-mode faults, the protection enable controls whether they can cause a shutdown.

The host reaches every register through an address-decoded 8-bit port. Read data arrives one cycle after the read strobe. Reading an event register clears it, and a separate clear-status strobe clears both event registers. The device's control logic drives the event inputs, and the host interface logic drives the register port.

Top module: `instr_status_regs`

## Requirements
- R1: A fault input bit latches into the fault register only when the same bit of the protection enable register is 1. Fault register bits: 1 constant-current, 2 converter, 4 over-temperature, 5 external shutdown, 6 foldback, 7 remote programming error. Bits 0 and 3 always read 0.
- R2: `shutdown_o` is 1 in the cycle after any of fault inputs 2, 4, 5 or 7 is high, whatever the enable. Fault inputs 1 and 6 cause a shutdown only while their protection enable bit is 1.
- R3: A standard event input sets its bit whatever the standard event enable holds. Standard event bits: 0 operation complete, 3 device error, 4 execution error, 5 command error, 7 power-on. Bits 1, 2 and 6 always read 0.
- R4: Status byte bit 5 is the OR of the standard event register ANDed bitwise with the standard event enable register.
- R5: `stb_o` is registered and follows the event registers one cycle later. Its bits: 1 is the OR of the fault register, 2 is `queue_nonempty`, 4 is `msg_avail`, 5 is the standard summary, 6 is the request bit. Bits 0, 3 and 7 are 0.
- R6: Status byte bit 6 and `srq_o` are both the OR of the other seven status bits ANDed with the service request enable. Bit 6 of that enable always reads 0 and has no effect.
- R7: Reading the fault register (address 0) or the standard event register (address 2) clears it. A one-cycle `clr_status` pulse clears both registers.
- R8: When an event and a clear arrive in the same cycle, the new event bit stays set. A read in that cycle returns the value held before the new event.
- R9: Reset sets all enable registers and the fault register to 0, and sets the standard event register to 0x80 (power-on).
- R10: Host addresses are: 0 fault (read-clear), 1 protection enable (bits 0 and 3 read 0), 2 standard event (read-clear), 3 standard event enable (bits 1, 2 and 6 read 0), 4 status byte, 5 service request enable. `host_rdata` and `host_rvalid` change at the clock edge that samples `host_rd`. Writes to addresses 0, 2 and 4 are ignored, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_evt | input | 8 | Fault event inputs, same bit map as the fault register |
| std_evt | input | 8 | Standard event inputs, same bit map as the standard event register |
| queue_nonempty | input | 1 | Error/event queue holds an entry |
| msg_avail | input | 1 | Output message available |
| clr_status | input | 1 | Clears both event registers |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, one cycle after the strobe |
| host_rvalid | output | 1 | Read data valid |
| shutdown_o | output | 1 | Registered shutdown request |
| srq_o | output | 1 | Service request |
| stb_o | output | 8 | Registered status byte |

## Verification
A table of fault patterns is paired with protection enables that cover three cases: mode faults with the enable cleared, mode faults with it set, and hard faults with the enable cleared. Comparing the latched register with the shutdown line for each pair separates the recording gate from the shutdown gate. The unused bits 0 and 3 are also driven, to confirm they are dropped. Directed sequences then cover:
- standard events with their enable at zero;
- a service-request enable with only bit 6 set;
- a read and an event in the same cycle, and a clear and an event in the same cycle;
- writes to read-only addresses.

These show that each mask gates only its own stage.

// File: rtl/instr_status_pkg.sv
package instr_status_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_FAULT   = 3'd0;
  localparam logic [AW-1:0] A_PROT_EN = 3'd1;
  localparam logic [AW-1:0] A_STD     = 3'd2;
  localparam logic [AW-1:0] A_STD_EN  = 3'd3;
  localparam logic [AW-1:0] A_STB     = 3'd4;
  localparam logic [AW-1:0] A_SRQ_EN  = 3'd5;

  // implemented bits of each register
  localparam logic [DW-1:0] FAULT_VALID  = 8'hF6;
  localparam logic [DW-1:0] STD_VALID    = 8'hB9;
  localparam logic [DW-1:0] SRQ_EN_VALID = 8'hBF;
  localparam logic [DW-1:0] STD_PWR_ON   = 8'h80;

  // faults that always shut down, and mode faults gated by enable
  localparam logic [DW-1:0] SD_ALWAYS = 8'hB4;
  localparam logic [DW-1:0] SD_GATED  = 8'h42;

  localparam int STB_PROT  = 1;
  localparam int STB_QUEUE = 2;
  localparam int STB_MSG   = 4;
  localparam int STB_STD   = 5;
  localparam int STB_RQS   = 6;
endpackage

// File: rtl/sticky_evt_reg.sv
module sticky_evt_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] VALID = '1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q
);
  logic [W-1:0] kept;
  assign kept = clr ? '0 : q;

  // a set in the clearing cycle wins over the clear
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= kept | (set_i & VALID);
  end
endmodule

// File: rtl/fault_shutdown.sv
module fault_shutdown
  import instr_status_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] fault_evt,
  input  logic [DW-1:0] prot_en,
  output logic          shutdown_q
);
  logic [DW-1:0] sd_mask;

  for (genvar i = 0; i < DW; i++) begin : g_mask
    if (SD_GATED[i]) begin : g_gated
      assign sd_mask[i] = prot_en[i];
    end else begin : g_fixed
      assign sd_mask[i] = SD_ALWAYS[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) shutdown_q <= 1'b0;
    else     shutdown_q <= |(fault_evt & sd_mask);
  end
endmodule

// File: rtl/status_summary.sv
module status_summary
  import instr_status_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] fault_q,
  input  logic [DW-1:0] std_q,
  input  logic [DW-1:0] std_en,
  input  logic [DW-1:0] srq_en,
  input  logic          queue_nonempty,
  input  logic          msg_avail,
  output logic [DW-1:0] stb_next,
  output logic [DW-1:0] stb_q,
  output logic          srq_q
);
  logic [DW-1:0] base;
  logic          rqs;

  always_comb begin
    base            = '0;
    base[STB_PROT]  = |fault_q;
    base[STB_QUEUE] = queue_nonempty;
    base[STB_MSG]   = msg_avail;
    base[STB_STD]   = |(std_q & std_en);
    rqs             = |(base & srq_en & SRQ_EN_VALID);
    stb_next        = base;
    stb_next[STB_RQS] = rqs;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= '0;
      srq_q <= 1'b0;
    end else begin
      stb_q <= stb_next;
      srq_q <= rqs;
    end
  end
endmodule

// File: rtl/host_regs.sv
module host_regs
  import instr_status_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] fault_q,
  input  logic [DW-1:0] std_q,
  input  logic [DW-1:0] stb_next,
  output logic [DW-1:0] prot_en,
  output logic [DW-1:0] std_en,
  output logic [DW-1:0] srq_en,
  output logic          fault_rd_clr,
  output logic          std_rd_clr,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  assign fault_rd_clr = rd && (addr == A_FAULT);
  assign std_rd_clr   = rd && (addr == A_STD);

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_en <= '0;
      std_en  <= '0;
      srq_en  <= '0;
    end else if (wr) begin
      case (addr)
        A_PROT_EN: prot_en <= wdata & FAULT_VALID;
        A_STD_EN:  std_en  <= wdata & STD_VALID;
        A_SRQ_EN:  srq_en  <= wdata & SRQ_EN_VALID;
        default:   ;
      endcase
    end
  end

  logic [DW-1:0] rmux;
  always_comb begin
    case (addr)
      A_FAULT:   rmux = fault_q;
      A_PROT_EN: rmux = prot_en;
      A_STD:     rmux = std_q;
      A_STD_EN:  rmux = std_en;
      A_STB:     rmux = stb_next;
      A_SRQ_EN:  rmux = srq_en;
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rmux;
    end
  end
endmodule

// File: rtl/instr_status_regs.sv
module instr_status_regs
  import instr_status_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] fault_evt,
  input  logic [DW-1:0] std_evt,
  input  logic          queue_nonempty,
  input  logic          msg_avail,
  input  logic          clr_status,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid,
  output logic          shutdown_o,
  output logic          srq_o,
  output logic [DW-1:0] stb_o
);
  logic [DW-1:0] fault_q, std_q, prot_en_q, std_en_q, srq_en_q, stb_next;
  logic          fault_rd_clr, std_rd_clr;

  sticky_evt_reg #(.W(DW), .VALID(FAULT_VALID), .RST_VAL('0)) u_fault (
    .clk(clk), .rst(rst), .clr(fault_rd_clr || clr_status),
    .set_i(fault_evt & prot_en_q), .q(fault_q)
  );

  sticky_evt_reg #(.W(DW), .VALID(STD_VALID), .RST_VAL(STD_PWR_ON)) u_std (
    .clk(clk), .rst(rst), .clr(std_rd_clr || clr_status),
    .set_i(std_evt), .q(std_q)
  );

  fault_shutdown u_sd (
    .clk(clk), .rst(rst), .fault_evt(fault_evt), .prot_en(prot_en_q),
    .shutdown_q(shutdown_o)
  );

  status_summary u_sum (
    .clk(clk), .rst(rst), .fault_q(fault_q), .std_q(std_q),
    .std_en(std_en_q), .srq_en(srq_en_q),
    .queue_nonempty(queue_nonempty), .msg_avail(msg_avail),
    .stb_next(stb_next), .stb_q(stb_o), .srq_q(srq_o)
  );

  host_regs u_host (
    .clk(clk), .rst(rst), .wr(host_wr), .rd(host_rd), .addr(host_addr),
    .wdata(host_wdata), .fault_q(fault_q), .std_q(std_q), .stb_next(stb_next),
    .prot_en(prot_en_q), .std_en(std_en_q), .srq_en(srq_en_q),
    .fault_rd_clr(fault_rd_clr), .std_rd_clr(std_rd_clr),
    .rdata(host_rdata), .rvalid(host_rvalid)
  );
endmodule

// File: rtl/instr_status_chk.sv
module instr_status_chk
  import instr_status_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] fault_evt,
  input logic [DW-1:0] std_evt,
  input logic          clr_status,
  input logic [DW-1:0] fault_q,
  input logic [DW-1:0] std_q,
  input logic [DW-1:0] prot_en_q,
  input logic [DW-1:0] std_en_q,
  input logic [DW-1:0] stb_o,
  input logic          srq_o,
  input logic          shutdown_o
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  a_r1_fault_gated: assert property (@(posedge clk) disable iff (rst || !armed)
    (fault_q & ~$past(fault_q) & ~$past(fault_evt & prot_en_q)) == '0);

  a_r2_shutdown: assert property (@(posedge clk) disable iff (rst || !armed)
    shutdown_o == |($past(fault_evt) & (SD_ALWAYS | ($past(prot_en_q) & SD_GATED))));

  a_r8_std_not_lost: assert property (@(posedge clk) disable iff (rst || !armed)
    (($past(std_evt) & STD_VALID) & ~std_q) == '0);

  a_r7_clear_status: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(clr_status) |-> ((std_q & ~$past(std_evt)) == '0));

  a_r4_std_summary: assert property (@(posedge clk) disable iff (rst || !armed)
    stb_o[STB_STD] == |($past(std_q) & $past(std_en_q)));

  a_r5_stb_unused: assert property (@(posedge clk) disable iff (rst || !armed)
    (stb_o & 8'h89) == '0);

  a_r6_srq_bit: assert property (@(posedge clk) disable iff (rst || !armed)
    srq_o == stb_o[STB_RQS]);
endmodule

bind instr_status_regs instr_status_chk u_chk (
  .clk(clk), .rst(rst), .fault_evt(fault_evt), .std_evt(std_evt),
  .clr_status(clr_status), .fault_q(fault_q), .std_q(std_q),
  .prot_en_q(prot_en_q), .std_en_q(std_en_q), .stb_o(stb_o),
  .srq_o(srq_o), .shutdown_o(shutdown_o)
);

// File: tb/instr_status_regs_test.sv
module instr_status_regs_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] fault_evt = '0, std_evt = '0, host_wdata = '0;
  logic       queue_nonempty = 1'b0, msg_avail = 1'b0, clr_status = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_rdata, stb_o;
  logic       host_rvalid, shutdown_o, srq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  instr_status_regs uut (
    .clk(clk), .rst(rst), .fault_evt(fault_evt), .std_evt(std_evt),
    .queue_nonempty(queue_nonempty), .msg_avail(msg_avail),
    .clr_status(clr_status), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .shutdown_o(shutdown_o), .srq_o(srq_o),
    .stb_o(stb_o)
  );

  // {fault input, protection enable, expected fault register, expected shutdown}
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    {8'h02, 8'h00, 8'h00, 8'h00},
    {8'h02, 8'h02, 8'h02, 8'h01},
    {8'h40, 8'h00, 8'h00, 8'h00},
    {8'h40, 8'hFF, 8'h40, 8'h01},
    {8'h04, 8'h00, 8'h00, 8'h01},
    {8'h10, 8'h10, 8'h10, 8'h01},
    {8'h09, 8'hFF, 8'h00, 8'h00},
    {8'hA0, 8'h20, 8'h20, 8'h01},
    {8'hFF, 8'hFF, 8'hF6, 8'h01}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic pulse_fault(input logic [7:0] v);
    @(negedge clk);
    fault_evt = v;
    @(negedge clk);
    fault_evt = '0;
  endtask

  task automatic pulse_std(input logic [7:0] v);
    @(negedge clk);
    std_evt = v;
    @(negedge clk);
    std_evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    check("R9 stb_o", stb_o, 8'h00);
    check("R9 srq_o", {7'b0, srq_o}, 8'h00);
    rd_reg(3'd1, d); check("R9 prot enable", d, 8'h00);
    check("R10 rvalid", {7'b0, host_rvalid}, 8'h01);
    rd_reg(3'd3, d); check("R9 std enable", d, 8'h00);
    rd_reg(3'd5, d); check("R9 srq enable", d, 8'h00);
    rd_reg(3'd2, d); check("R9 power-on bit", d, 8'h80);
    rd_reg(3'd2, d); check("R7 read clears std", d, 8'h00);

    // R1 R2 table of fault patterns
    for (int i = 0; i < NV; i++) begin
      wr_reg(3'd1, VEC[i][23:16]);
      pulse_fault(VEC[i][31:24]);
      check("R2 shutdown", {7'b0, shutdown_o}, VEC[i][7:0]);
      rd_reg(3'd0, d);
      check("R1 fault latch", d, VEC[i][15:8]);
    end
    rd_reg(3'd1, d); check("R10 prot enable readback", d, 8'hF6);
    rd_reg(3'd0, d); check("R7 fault cleared by read", d, 8'h00);

    // R5 protection summary
    wr_reg(3'd1, 8'h04);
    pulse_fault(8'h04);
    @(negedge clk);
    check("R5 prot summary", stb_o, 8'h02);
    rd_reg(3'd0, d);
    @(negedge clk);
    check("R5 summary drops", stb_o, 8'h00);

    // R3 events set without enable; unused bits ignored
    pulse_std(8'h10);
    rd_reg(3'd2, d); check("R3 set without enable", d, 8'h10);
    pulse_std(8'h46);
    rd_reg(3'd2, d); check("R3 unused bits", d, 8'h00);

    // R4 R6 summary and service request
    wr_reg(3'd3, 8'h10);
    wr_reg(3'd5, 8'h20);
    pulse_std(8'h10);
    @(negedge clk);
    check("R4 std summary", stb_o, 8'h60);
    check("R6 srq_o set", {7'b0, srq_o}, 8'h01);
    rd_reg(3'd4, d); check("R10 status read", d, 8'h60);
    @(negedge clk);
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
    @(negedge clk);
    check("R7 clr_status", stb_o, 8'h00);
    check("R6 srq_o clears", {7'b0, srq_o}, 8'h00);

    // R5 queue and message bits
    queue_nonempty = 1'b1; msg_avail = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R5 queue and msg", stb_o, 8'h14);

    // R6 enable bit 6 has no effect
    wr_reg(3'd5, 8'h40);
    rd_reg(3'd5, d); check("R6 enable bit6 reads 0", d, 8'h00);
    @(negedge clk);
    check("R6 bit6 enable ignored", {7'b0, srq_o}, 8'h00);
    wr_reg(3'd5, 8'h10);
    @(negedge clk);
    check("R6 msg request", {7'b0, srq_o}, 8'h01);
    check("R6 stb bit6", stb_o, 8'h54);
    queue_nonempty = 1'b0; msg_avail = 1'b0;

    // R8 event in the same cycle as a read
    wr_reg(3'd1, 8'h14);
    pulse_fault(8'h04);
    @(negedge clk);
    fault_evt = 8'h10; host_rd = 1'b1; host_addr = 3'd0;
    @(negedge clk);
    fault_evt = '0; host_rd = 1'b0;
    check("R8 read returns old", host_rdata, 8'h04);
    rd_reg(3'd0, d); check("R8 new fault kept", d, 8'h10);

    // R8 event in the same cycle as clr_status
    pulse_std(8'h08);
    @(negedge clk);
    clr_status = 1'b1; std_evt = 8'h01;
    @(negedge clk);
    clr_status = 1'b0; std_evt = '0;
    rd_reg(3'd2, d); check("R8 std event survives clear", d, 8'h01);

    // R10 writes to read-only addresses ignored
    pulse_std(8'h20);
    wr_reg(3'd2, 8'h00);
    rd_reg(3'd2, d); check("R10 std write ignored", d, 8'h20);
    wr_reg(3'd0, 8'hFF);
    rd_reg(3'd0, d); check("R10 fault write ignored", d, 8'h00);
    rd_reg(3'd6, d); check("R10 unused address", d, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule